// File: doc/BRIEF.md
# Parallel Multi-Lane String Matcher

This block scans a data stream that arrives one multi-byte word per clock and reports when a programmed search string has appeared. The string is not matched by one wide automaton. It is dealt out into as many interleaved substrings as there are byte lanes. Each byte lane drives its own byte-wide, table-driven matcher, and every lane looks for all of the substrings. A combine stage then decides whether the substring hits from all lanes line up to form the whole string at one of the possible byte alignments. Both the current word and the previous accepted word are considered.

Software computes the transition tables and writes them through a single table port. Every write lands in all lane tables at once, so the lanes always hold identical contents. A qualifier marks the words that take part in the search. The words in between are ignored and do not break a string that spans them.

Top module: `interleaved_string_matcher`

## Requirements
- R1: After reset, `match_o` is low and every lane matcher is in state 0, which is the root state of the programmed automaton.
- R2: Byte lane x takes bits [8x+7:8x] of `in_data`. In stream order, lane 0 holds the earliest byte of a word and lane LANES-1 holds the latest.
- R3: For a pattern of length L (L >= LANES), substring k holds the pattern bytes whose index j satisfies j mod LANES = (L - LANES + k) mod LANES, in increasing j. Substrings are therefore numbered by the order in which their last byte arrives. Table entry (state s, byte b) holds the next state and a LANES-bit vector in which bit k is set when substring k ends on byte b.
- R4: A full occurrence of the pattern is reported wherever its last byte falls: in any lane, and whether it lies in one word or spans two.
- R5: `match_o` rises in the cycle that follows the clock edge accepting the word with the pattern's last byte. It stays high for exactly one cycle per such word.
- R6: On a cycle with `in_valid` low, every lane state and the stored previous-word hit vectors are held. The data on that cycle has no effect, so a pattern split by idle cycles is still found.
- R7: A cycle with `in_valid` low gives a low `match_o` on the following cycle.
- R8: A write on the table port updates the entry at {`tbl_state`, `tbl_byte`} in all lane tables together. After a reset, a reprogrammed pattern is searched and the old one is no longer reported.
- R9: A stream without a complete occurrence of the pattern never raises `match_o`. This covers partial prefixes and substrings that hit at inconsistent alignments.
- R10: Occurrences that overlap are each reported at the word that holds their own last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of lane states, stored hits and the output |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | LANES*8 | Input word, lane 0 in the low byte |
| tbl_we | input | 1 | Table write strobe, applied to all lanes |
| tbl_state | input | STATE_BITS | State part of the table address |
| tbl_byte | input | 8 | Input-byte part of the table address |
| tbl_next | input | STATE_BITS | Next state to store |
| tbl_hits | input | LANES | Substring hit vector to store |
| match_o | output | 1 | Registered full-string match |

## Verification
On every cycle, the assertions check the timing rules: lane states and stored previous-word hits are frozen while `in_valid` is low, and `match_o` is low after an idle cycle. They also check that `match_o` follows the combine result of the last accepted word, and that no full hit appears unless the last substring completed in some lane. Some behaviours can only be shown by the bench scenarios, which compare the output with a plain byte-stream search. These are correct detection at every alignment, words that span idle gaps, overlapping occurrences, the lack of false hits on partial strings, and the effect of reprogramming the tables.

// File: rtl/ism_pkg.sv
package ism_pkg;

  // Lane in which substring `sub` completes for alignment `align`:
  // the last pattern byte sits in lane LANES-1-align.
  function automatic int src_lane(input int sub, input int align, input int lanes);
    return (sub - align + lanes) % lanes;
  endfunction

  // Substrings with index below the alignment completed in the previous word.
  function automatic bit from_prev(input int sub, input int align);
    return sub < align;
  endfunction

endpackage

// File: rtl/ism_lane_fsm.sv
module ism_lane_fsm #(
  parameter int LANES      = 4,
  parameter int STATE_BITS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_i,
  input  logic [7:0]            byte_i,
  input  logic                  we_i,
  input  logic [STATE_BITS-1:0] wr_state_i,
  input  logic [7:0]            wr_byte_i,
  input  logic [STATE_BITS-1:0] wr_next_i,
  input  logic [LANES-1:0]      wr_hits_i,
  output logic [LANES-1:0]      hits_o
);
  localparam int STATES = 1 << STATE_BITS;
  localparam int DEPTH  = STATES * 256;
  localparam int EW     = STATE_BITS + LANES;

  logic [EW-1:0]         tbl_mem [DEPTH];
  logic [STATE_BITS-1:0] state_q;
  logic [EW-1:0]         rd_entry;
  logic [STATE_BITS-1:0] next_state;

  always_ff @(posedge clk) begin
    if (we_i) tbl_mem[{wr_state_i, wr_byte_i}] <= {wr_next_i, wr_hits_i};
  end

  assign rd_entry   = tbl_mem[{state_q, byte_i}];
  assign next_state = rd_entry[EW-1:LANES];
  assign hits_o     = valid_i ? rd_entry[LANES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= '0;
    else if (valid_i) state_q <= next_state;
  end

  // R6
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(state_q));

endmodule

// File: rtl/ism_combine.sv
module ism_combine
  import ism_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_i,
  input  logic [LANES*LANES-1:0]   hits_i,   // index lane*LANES + substring
  output logic                     full_hit_o
);
  logic [LANES*LANES-1:0]          prev_q;
  logic [LANES-1:0][LANES-1:0]     term;
  logic [LANES-1:0]                align_hit;
  logic                            last_sub_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)       prev_q <= '0;
    else if (valid_i) prev_q <= hits_i;
  end

  for (genvar c = 0; c < LANES; c++) begin : g_align
    for (genvar i = 0; i < LANES; i++) begin : g_term
      localparam int SRC = src_lane(i, c, LANES);
      localparam int IDX = SRC * LANES + i;
      if (from_prev(i, c)) begin : g_old
        assign term[c][i] = prev_q[IDX];
      end else begin : g_cur
        assign term[c][i] = hits_i[IDX];
      end
    end
    assign align_hit[c] = &term[c];
  end

  assign full_hit_o = |align_hit;

  logic [LANES-1:0] last_col;
  for (genvar x = 0; x < LANES; x++) begin : g_last
    assign last_col[x] = hits_i[x*LANES + LANES-1];
  end
  assign last_sub_seen = |last_col;

  // R6
  prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(prev_q));

  // R9
  needs_last_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_sub_seen |-> !full_hit_o);

endmodule

// File: rtl/interleaved_string_matcher.sv
module interleaved_string_matcher #(
  parameter int LANES      = 4,
  parameter int STATE_BITS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*8-1:0]      in_data,
  input  logic                    tbl_we,
  input  logic [STATE_BITS-1:0]   tbl_state,
  input  logic [7:0]              tbl_byte,
  input  logic [STATE_BITS-1:0]   tbl_next,
  input  logic [LANES-1:0]        tbl_hits,
  output logic                    match_o
);
  localparam int NHITS = LANES * LANES;

  logic [NHITS-1:0] lane_hits;
  logic             full_hit;
  logic             match_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ism_lane_fsm #(.LANES(LANES), .STATE_BITS(STATE_BITS)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_i    (in_valid),
      .byte_i     (in_data[8*g +: 8]),
      .we_i       (tbl_we),
      .wr_state_i (tbl_state),
      .wr_byte_i  (tbl_byte),
      .wr_next_i  (tbl_next),
      .wr_hits_i  (tbl_hits),
      .hits_o     (lane_hits[g*LANES +: LANES])
    );
  end

  ism_combine #(.LANES(LANES)) u_combine (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (in_valid),
    .hits_i     (lane_hits),
    .full_hit_o (full_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= in_valid & full_hit;
  end
  assign match_o = match_q;

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !match_o);

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (match_o == $past(full_hit)));

endmodule

// File: tb/interleaved_string_matcher_test.sv
module interleaved_string_matcher_test;
  localparam int LANES = 4;
  localparam int SB    = 3;
  localparam int NST   = 1 << SB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [LANES*8-1:0] in_data = '0;
  logic tbl_we = 1'b0;
  logic [SB-1:0] tbl_state = '0;
  logic [7:0] tbl_byte = '0;
  logic [SB-1:0] tbl_next = '0;
  logic [LANES-1:0] tbl_hits = '0;
  logic match_o;

  interleaved_string_matcher #(.LANES(LANES), .STATE_BITS(SB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .tbl_we(tbl_we), .tbl_state(tbl_state), .tbl_byte(tbl_byte),
    .tbl_next(tbl_next), .tbl_hits(tbl_hits), .match_o(match_o));

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // pattern and reference model state
  byte unsigned pat[8];
  int plen;
  int sub_len[LANES];
  byte unsigned sub_c[LANES][2];
  int nn;
  int nlen[NST];
  byte unsigned nc[NST][2];
  byte unsigned hist[8];
  int hcount;
  bit exp_q;
  string cur_req;

  task automatic check(input string req, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: match_o=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  function automatic int find_node(byte unsigned a0, byte unsigned a1, int l);
    for (int n = 0; n < nn; n++) begin
      if (nlen[n] == l) begin
        if (l == 0) return n;
        if (l == 1 && nc[n][0] == a0) return n;
        if (l == 2 && nc[n][0] == a0 && nc[n][1] == a1) return n;
      end
    end
    return -1;
  endfunction

  // R3: deal the pattern into substrings and build their trie
  task automatic build_nodes();
    for (int k = 0; k < LANES; k++) sub_len[k] = 0;
    for (int j = 0; j < plen; j++) begin
      int k = (j - (plen - LANES) + 2 * LANES) % LANES;
      sub_c[k][sub_len[k]] = pat[j];
      sub_len[k]++;
    end
    nn = 1;
    nlen[0] = 0;
    for (int k = 0; k < LANES; k++)
      for (int p = 1; p <= sub_len[k]; p++)
        if (find_node(sub_c[k][0], sub_c[k][1], p) < 0) begin
          nlen[nn] = p;
          nc[nn][0] = sub_c[k][0];
          nc[nn][1] = sub_c[k][1];
          nn++;
        end
  endtask

  function automatic int next_node(int s, byte unsigned b);
    byte unsigned t[3];
    int tl;
    tl = nlen[s] + 1;
    for (int q = 0; q < nlen[s]; q++) t[q] = nc[s][q];
    t[nlen[s]] = b;
    for (int l = (tl > 2 ? 2 : tl); l >= 0; l--) begin
      int f = find_node(t[tl-l], (l >= 2) ? t[tl-l+1] : 8'd0, l);
      if (f >= 0) return f;
    end
    return 0;
  endfunction

  function automatic logic [LANES-1:0] node_hits(int n);
    logic [LANES-1:0] h = '0;
    for (int k = 0; k < LANES; k++) begin
      if (sub_len[k] <= nlen[n]) begin
        bit ok = 1'b1;
        for (int q = 0; q < sub_len[k]; q++)
          if (nc[n][nlen[n]-sub_len[k]+q] != sub_c[k][q]) ok = 1'b0;
        h[k] = ok;
      end
    end
    return h;
  endfunction

  task automatic program_table(input string p);
    plen = p.len();
    for (int j = 0; j < plen; j++) pat[j] = p[j];
    build_nodes();
    for (int s = 0; s < NST; s++) begin
      for (int b = 0; b < 256; b++) begin
        int nx = (s < nn) ? next_node(s, 8'(b)) : 0;
        @(negedge clk);
        tbl_we    = 1'b1;
        tbl_state = SB'(s);
        tbl_byte  = 8'(b);
        tbl_next  = SB'(nx);
        tbl_hits  = node_hits(nx);
      end
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hcount = 0;
    exp_q = 1'b0;
    @(negedge clk);
    check("R1", match_o, 1'b0);
  endtask

  // plain stream search: does the pattern end on the byte just pushed?
  function automatic bit push_byte(byte unsigned b);
    for (int q = 0; q < 7; q++) hist[q] = hist[q+1];
    hist[7] = b;
    if (hcount < 8) hcount++;
    if (hcount < plen) return 1'b0;
    for (int q = 0; q < plen; q++)
      if (hist[8-plen+q] != pat[q]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step(input bit v, input logic [LANES*8-1:0] d);
    @(negedge clk);
    check(cur_req, match_o, exp_q);
    in_valid = v;
    in_data  = d;
    exp_q = 1'b0;
    if (v)
      for (int x = 0; x < LANES; x++)            // R2: lane 0 first
        if (push_byte(d[8*x +: 8])) exp_q = 1'b1;
  endtask

  task automatic flush();
    step(1'b0, '0);
    step(1'b0, '0);
  endtask

  // send: `lead` filler bytes, the pattern, filler to word end; gaps optional
  task automatic send_aligned(input int lead, input bit gaps, input bit cut_last);
    byte unsigned buf_b[32];
    int n = 0;
    for (int q = 0; q < lead; q++) buf_b[n++] = "z";
    for (int q = 0; q < plen; q++) buf_b[n++] = pat[q];
    if (cut_last) buf_b[n-1] = "y";
    while (n % LANES != 0 || n < 2 * LANES) buf_b[n++] = "z";
    for (int w = 0; w < n / LANES; w++) begin
      logic [LANES*8-1:0] d;
      for (int x = 0; x < LANES; x++) d[8*x +: 8] = buf_b[w*LANES + x];
      step(1'b1, d);
      if (gaps) begin
        step(1'b0, {LANES{pat[plen-1]}});
        step(1'b0, $urandom);
      end
    end
    flush();
  endtask

  task automatic random_run(input int words, input int valid_pct);
    for (int w = 0; w < words; w++) begin
      logic [LANES*8-1:0] d;
      bit v = ($urandom % 100) < valid_pct;
      for (int x = 0; x < LANES; x++)
        d[8*x +: 8] = (($urandom % 8) == 0) ? 8'($urandom) : pat[$urandom % plen];
      step(v, d);
    end
    flush();
  endtask

  initial begin
    void'($urandom(32'd20251));
    hcount = 0;
    exp_q = 1'b0;
    cur_req = "R1";
    repeat (2) @(negedge clk);

    // first pattern, L=6
    program_table("abcdef");
    do_reset();
    cur_req = "R4";
    for (int a = 0; a < LANES; a++) send_aligned(a, 1'b0, 1'b0);
    cur_req = "R6";
    for (int a = 0; a < LANES; a++) send_aligned(a, 1'b1, 1'b0);
    cur_req = "R9";
    for (int a = 0; a < LANES; a++) send_aligned(a, 1'b0, 1'b1);
    cur_req = "R7";
    random_run(1500, 70);
    cur_req = "R5";
    random_run(800, 100);

    // reprogram, L=7
    program_table("cabbage");
    do_reset();
    cur_req = "R8";
    for (int a = 0; a < LANES; a++) send_aligned(a, 1'b0, 1'b0);
    random_run(1500, 80);

    // overlapping occurrences
    program_table("ababab");
    do_reset();
    cur_req = "R10";
    step(1'b1, "baba");   // bytes a,b,a,b in lane order 0..3
    step(1'b1, "baba");
    step(1'b1, "baba");
    step(1'b1, "zzzz");
    flush();
    cur_req = "R3";
    random_run(1500, 85);

    finish_run();
  end
endmodule